// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a 16-bit timer channel that counts down once for each pulse of a selected count source. Four count-source enable strobes arrive as inputs. They are synchronous to the system clock, and a 2-bit field in the mode register picks one of them. When the counter is at zero and the next pulse arrives, the counter takes the value held in a reload register and an interrupt request pulse is raised. A programmed value n therefore gives one request every n+1 source pulses.

Software sees three things: a timer register, a mode register and a start bit. A read of the timer register returns the live counter. Where a write to the timer register lands depends on a "first pulse seen" flag. While the channel is stopped, or after a start and before the first counted pulse, the write goes to both the counter and the reload register. After that first pulse it goes only to the reload register, and the counter picks the new value up at its next reload.

Top module: `reload_timer`

## Requirements
- R1: While the start bit is 1 and the operation-mode field is 00, each strobe on the selected source decrements a nonzero counter by one. In every other case the counter holds, unless a write reaches it.
- R2: A selected strobe that arrives while the counter is 0 loads the counter from the reload register, so with reload value n the period is n+1 strobes. If a timer write happens in that same cycle, the newly written reload value is loaded.
- R3: `irq_o` is high for exactly the one cycle after each cycle in which an underflow reload took place.
- R4: `cnt_o` always shows the live counter, never the reload register.
- R5: While the channel is stopped, or after a start and before the first counted strobe, a timer write loads both the counter and the reload register.
- R6: After the first counted strobe since start, a timer write changes only the reload register. Counting goes on from the old value.
- R7: Source select value s (0 to 3) picks `src_tick_i[s]`. Index 0 is the fastest source and index 3 is the low-speed one. Strobes on the other sources have no effect.
- R8: Mode register layout: bits [1:0] hold the operation mode and bits [7:6] hold the source select. `mode_o` returns those fields and reads 0 in bits [5:2]. When the mode is not 00, no counting takes place.
- R9: `run_o` follows the last start-bit write. A 0-to-1 start write clears the first-pulse flag, and a write of 1 while already running leaves the flag as it is.
- R10: During reset the counter, the reload register, the start bit and both mode fields are 0, and `irq_o` is low.
- R11: If a timer write and a counted strobe fall in the same cycle, the write is routed by the flag as it stood before that strobe. When the write reaches the counter, it wins: there is no decrement and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | Count-source enable strobes, one cycle wide |
| wr_cnt_i | input | 1 | Timer register write strobe |
| wdata_cnt_i | input | 16 | Timer register write data |
| wr_mode_i | input | 1 | Mode register write strobe |
| wdata_mode_i | input | 8 | Mode register write data |
| wr_run_i | input | 1 | Start bit write strobe |
| wdata_run_i | input | 1 | Start bit write data |
| cnt_o | output | 16 | Live counter value |
| mode_o | output | 8 | Mode register readback |
| run_o | output | 1 | Start bit |
| irq_o | output | 1 | Underflow interrupt request pulse |

## Verification
The assertions assume that every source strobe and every write strobe is synchronous to `clk_i` and is sampled once per edge. They also assume that a write strobe carries valid data in the same cycle. The stimulus keeps to this: all inputs change only on the falling edge, every strobe is a plain per-cycle level, and write data is set together with its strobe. Strobes on unselected sources and back-to-back strobes are drawn at random on purpose, so that the assertions on hold, reload and write routing are exercised under overlap.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned N_SRC  = 4;
  localparam int unsigned SEL_W  = $clog2(N_SRC);
  localparam int unsigned MODE_W = 8;

  typedef enum logic [1:0] {
    OP_TIMER = 2'b00,
    OP_RSV1  = 2'b01,
    OP_RSV2  = 2'b10,
    OP_RSV3  = 2'b11
  } op_mode_e;
endpackage

// File: rtl/rt_src_sel.sv
module rt_src_sel #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_dec
    assign hit[g] = src_tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import reload_timer_pkg::*;
#(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mode_i,
  input  logic [MODE_W-1:0] wdata_mode_i,
  input  logic              wr_run_i,
  input  logic              wdata_run_i,
  input  logic              wr_cnt_i,
  input  logic              src_tick_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              run_o,
  output logic              seen_o,
  output logic              tick_o,
  output logic              wr_both_o
);
  op_mode_e         op_q;
  logic [SEL_W-1:0] sel_q;
  logic             run_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_TIMER;
      sel_q <= '0;
    end else if (wr_mode_i) begin
      op_q  <= op_mode_e'(wdata_mode_i[1:0]);
      sel_q <= wdata_mode_i[MODE_W-1 -: SEL_W];
    end
  end

  assign tick_o = src_tick_i && run_q && (op_q == OP_TIMER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (wr_run_i) run_q <= wdata_run_i;
      if (wr_run_i && wdata_run_i && !run_q) seen_q <= 1'b0;
      else if (tick_o)                       seen_q <= 1'b1;
    end
  end

  // routing uses the flag as it stood before a same-cycle tick
  assign wr_both_o = wr_cnt_i && (!run_q || !seen_q);

  always_comb begin
    mode_o                      = '0;
    mode_o[1:0]                 = op_q;
    mode_o[MODE_W-1 -: SEL_W]   = sel_q;
  end

  assign sel_o  = sel_q;
  assign run_o  = run_q;
  assign seen_o = seen_q;
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_both_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, reload_q, reload_nx;
  logic             zero, uflow;

  assign reload_nx = wr_cnt_i ? wdata_i : reload_q;
  assign zero      = (cnt_q == '0);
  assign uflow     = tick_i && zero && !wr_both_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      reload_q <= reload_nx;
      irq_q    <= uflow;
      if (wr_both_i)   cnt_q <= wdata_i;
      else if (uflow)  cnt_q <= reload_nx;
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  logic irq_q;
  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_tick_i,
  input  logic              wr_cnt_i,
  input  logic [CNT_W-1:0]  wdata_cnt_i,
  input  logic              wr_mode_i,
  input  logic [MODE_W-1:0] wdata_mode_i,
  input  logic              wr_run_i,
  input  logic              wdata_run_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              run_o,
  output logic              irq_o
);
  logic [SEL_W-1:0] sel;
  logic             sel_tick, tick, wr_both, seen_q;
  logic [CNT_W-1:0] reload_q;

  rt_src_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
    .src_tick_i (src_tick_i),
    .sel_i      (sel),
    .tick_o     (sel_tick)
  );

  rt_ctrl #(.SEL_W(SEL_W), .MODE_W(MODE_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_mode_i    (wr_mode_i),
    .wdata_mode_i (wdata_mode_i),
    .wr_run_i     (wr_run_i),
    .wdata_run_i  (wdata_run_i),
    .wr_cnt_i     (wr_cnt_i),
    .src_tick_i   (sel_tick),
    .sel_o        (sel),
    .mode_o       (mode_o),
    .run_o        (run_o),
    .seen_o       (seen_q),
    .tick_o       (tick),
    .wr_both_o    (wr_both)
  );

  rt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_cnt_i  (wr_cnt_i),
    .wr_both_i (wr_both),
    .wdata_i   (wdata_cnt_i),
    .cnt_o     (cnt_o),
    .reload_o  (reload_q),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             irq_i,
  input logic             run_i,
  input logic             seen_i,
  input logic             wr_cnt_i
);
  // R3: a request only follows a running cycle with the counter at zero
  a_r3_irq_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ($past(cnt_i) == '0 && $past(run_i)));

  // R2: in the request cycle the counter holds the reload value
  a_r2_reload_on_uflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (cnt_i == reload_i));

  // R1: stopped and no write means the counter holds
  a_r1_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_cnt_i) |=> $stable(cnt_i));

  // R6: once the flag is set, a write moves the counter at most by one step or a reload
  a_r6_reload_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt_i && run_i && seen_i) |=>
      (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) - 1'b1 || $past(cnt_i) == '0));

  // R10: reset values
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r10_reset_state: assert (cnt_i == '0 && reload_i == '0 && !irq_i && !run_i);
    end
  end
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(reload_timer_pkg::CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_o),
  .reload_i (reload_q),
  .irq_i    (irq_o),
  .run_i    (run_o),
  .seen_i   (seen_q),
  .wr_cnt_i (wr_cnt_i)
);

// File: tb/reload_timer_tb_top.sv
`timescale 1ns/1ps
module reload_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  src_tick_i = '0;
  logic        wr_cnt_i = 1'b0, wr_mode_i = 1'b0, wr_run_i = 1'b0, wdata_run_i = 1'b0;
  logic [15:0] wdata_cnt_i = '0;
  logic [7:0]  wdata_mode_i = '0;
  logic [15:0] cnt_o;
  logic [7:0]  mode_o;
  logic        run_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // expected state
  logic [15:0] m_cnt = '0, m_rel = '0;
  logic [1:0]  m_op = '0, m_sel = '0;
  logic        m_run = 0, m_seen = 0, m_irq = 0;

  always #2.5 clk_i = ~clk_i;

  reload_timer dut_i (.*);

  function automatic logic [7:0] exp_mode();
    return {m_sel, 4'b0000, m_op};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, 32'(cnt_o), 32'(m_cnt));
    chk("R3 irq", 32'(irq_o), 32'(m_irq));
    chk("R8 mode", 32'(mode_o), 32'(exp_mode()));
    chk("R9 run", 32'(run_o), 32'(m_run));
  endtask

  // one clock: apply at negedge, model the edge, check at next negedge
  task automatic step(input logic [3:0] src, input logic wc, input logic [15:0] dc,
                      input logic wm, input logic [7:0] dm, input logic wr, input logic dr,
                      input string tag);
    logic tick, both;
    logic [15:0] rel_nx;
    src_tick_i = src; wr_cnt_i = wc; wdata_cnt_i = dc;
    wr_mode_i = wm; wdata_mode_i = dm; wr_run_i = wr; wdata_run_i = dr;
    tick   = m_run && (m_op == 2'b00) && src[m_sel];
    both   = wc && (!m_run || !m_seen);
    rel_nx = wc ? dc : m_rel;
    m_irq  = tick && !both && (m_cnt == 0);
    if (both) m_cnt = dc;
    else if (tick) m_cnt = (m_cnt == 0) ? rel_nx : m_cnt - 16'd1;
    m_rel = rel_nx;
    if (wr && dr && !m_run) m_seen = 0; else if (tick) m_seen = 1;
    if (wr) m_run = dr;
    if (wm) begin m_op = dm[1:0]; m_sel = dm[7:6]; end
    @(negedge clk_i);
    chk_all(tag);
  endtask

  task automatic idle(input logic [3:0] src, input string tag);
    step(src, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    chk("R10 cnt", 32'(cnt_o), 0);
    chk("R10 irq", 32'(irq_o), 0);
    chk("R10 mode", 32'(mode_o), 0);
    chk("R10 run", 32'(run_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 stopped write loads counter; R4 readback is counter
    step(4'b0000, 1, 16'd3, 0, 0, 0, 0, "R5");
    chk("R5 cnt", 32'(cnt_o), 3);
    idle(4'b1111, "R1 stopped hold");
    chk("R1 hold", 32'(cnt_o), 3);
    // start, then R2 period n+1 = 4 ticks
    step(4'b0000, 0, 0, 0, 0, 1, 1, "R9");
    idle(4'b0001, "R1"); chk("R1 dec", 32'(cnt_o), 2);
    idle(4'b0010, "R7 unselected"); chk("R7 ignore", 32'(cnt_o), 2);
    idle(4'b0001, "R1"); idle(4'b0001, "R1");
    chk("R2 zero", 32'(cnt_o), 0); chk("R3 low", 32'(irq_o), 0);
    idle(4'b0001, "R2");
    chk("R2 reload", 32'(cnt_o), 3); chk("R3 pulse", 32'(irq_o), 1);
    idle(4'b0000, "R3"); chk("R3 single", 32'(irq_o), 0);
    // R6 mid-count write only to reload
    step(4'b0000, 1, 16'd9, 0, 0, 0, 0, "R6");
    chk("R6 cnt unchanged", 32'(cnt_o), 3);
    chk("R4 readback", 32'(cnt_o), 3);
    repeat (4) idle(4'b0001, "R6");
    chk("R6 new reload", 32'(cnt_o), 9); chk("R3 irq", 32'(irq_o), 1);
    // R9 restart clears flag: R5 write before first tick
    step(4'b0000, 0, 0, 0, 0, 1, 0, "R9 stop");
    step(4'b0000, 0, 0, 0, 0, 1, 1, "R9 start");
    step(4'b0000, 1, 16'd5, 0, 0, 0, 0, "R5 pre-tick");
    chk("R5 both", 32'(cnt_o), 5);
    // R11 same-cycle write + first tick: write wins counter
    step(4'b0001, 1, 16'd7, 0, 0, 0, 0, "R11");
    chk("R11 write wins", 32'(cnt_o), 7);
    step(4'b0001, 1, 16'd2, 0, 0, 0, 0, "R11 after");
    chk("R11 reload only", 32'(cnt_o), 6);
    // R7 select index 3
    step(4'b0000, 0, 0, 1, 8'hC0, 0, 0, "R7");
    chk("R8 readback", 32'(mode_o), 32'hC0);
    idle(4'b0111, "R7"); chk("R7 ignore low", 32'(cnt_o), 6);
    idle(4'b1000, "R7"); chk("R7 sel3", 32'(cnt_o), 5);
    // R8 non-timer mode suppresses counting, reserved bits read 0
    step(4'b0000, 0, 0, 1, 8'h3D, 0, 0, "R8");
    chk("R8 rsv bits", 32'(mode_o), 32'h01);
    idle(4'b1111, "R8"); chk("R8 hold", 32'(cnt_o), 5);
    step(4'b0000, 0, 0, 1, 8'h00, 0, 0, "R8");
    // R2 n=0: every tick underflows
    step(4'b0000, 0, 0, 0, 0, 1, 0, "R9");
    step(4'b0000, 1, 16'd0, 0, 0, 1, 1, "R5");
    idle(4'b0001, "R2"); chk("R2 n0 irq", 32'(irq_o), 1);
    idle(4'b0001, "R2"); chk("R2 n0 irq again", 32'(irq_o), 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  s;
      logic        wc, wm, wr;
      logic [15:0] dc;
      logic [7:0]  dm;
      s  = 4'($urandom) & 4'($urandom);
      wc = ($urandom % 16) == 0;
      dc = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 6);
      wm = ($urandom % 50) == 0;
      dm = ($urandom % 4 == 0) ? 8'($urandom) : (8'($urandom) & 8'hC0);
      wr = ($urandom % 30) == 0;
      step(s, wc, dc, wm, dm, wr, 1'($urandom % 4 != 0), "R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule